// File: doc/BRIEF.md
# Multi-Level Tag-Matching Operand Bypass

This block supplies the two source operands (left and right) for one execution lane. It needs no central bypass control. Every execution lane broadcasts its single result each cycle, together with a valid bit and the destination tag that also steers the register-file write. A register-file write takes DEPTH cycles to become readable. Each lane therefore keeps its broadcasts in a short history chain. A result broadcast in cycle t can be forwarded to a source presented in any cycle from t to t+DEPTH-1.

For each operand, the block compares the source tag against every held result at once: every lane at every history level. A valid match supplies the forwarded value. When nothing matches, the operand takes the value read from the payload RAM or register file. When more than one level matches, the youngest level wins. Within a single level, the tags of the lanes are expected to be distinct. The chosen operands are registered once on their way to the functional units.

The design has no state machine. It consists of per-lane history shift registers, two priority compare trees and one output register stage.

Top module: `bp_operand_net`

## Requirements
- R1: While reset is asserted, and after it is released, `op_valid_o` is 0 and both operand outputs are 0 until the first issue is accepted.
- R2: `op_valid_o` equals `issue_valid_i` delayed by exactly one clock.
- R3: When a source tag equals the tag of a valid result broadcast in the same cycle as the issue, the operand output one clock later is that lane's result data.
- R4: A valid result broadcast 1 to DEPTH-1 cycles before the issue is forwarded to a source with the same tag.
- R5: When no held result matches a source tag, the operand output is the register-file value presented with the issue.
- R6: A result broadcast DEPTH or more cycles before the issue is never forwarded; the register-file value is used instead.
- R7: A broadcast whose valid bit is 0 never matches, even when its tag equals the source tag.
- R8: When results at several history levels match, the data from the most recent level is used.
- R9: The left and right operands are resolved independently. Each may select a different lane, a different level, or the register file in the same cycle.
- R10: In a cycle with `issue_valid_i` low, both operand outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid_i | input | LANES | Per-lane result broadcast valid; bit n is lane n |
| res_tag_i | input | LANES*TAG_W | Per-lane destination tag; lane n at bits [n*TAG_W +: TAG_W] |
| res_data_i | input | LANES*DATA_W | Per-lane result value; lane n at bits [n*DATA_W +: DATA_W] |
| issue_valid_i | input | 1 | An instruction is issued to this lane this cycle |
| src_l_tag_i | input | TAG_W | Left source tag |
| src_r_tag_i | input | TAG_W | Right source tag |
| rf_l_data_i | input | DATA_W | Left operand read from payload/register file |
| rf_r_data_i | input | DATA_W | Right operand read from payload/register file |
| op_valid_o | output | 1 | Registered operands valid |
| op_l_data_o | output | DATA_W | Registered left operand |
| op_r_data_o | output | DATA_W | Registered right operand |

## Verification
The hardest case to reach is a tag that matches at two history levels at once, where only the age ordering decides which value is returned. The stimulus creates it by broadcasting the same tag from different lanes with different data in consecutive cycles, then issuing against that tag. The window edge is the other difficult point. One result is followed cycle by cycle, and the expected source switches from the forwarded value to the register-file value exactly DEPTH cycles after the broadcast.

// File: rtl/bypass_net_pkg.sv
package bypass_net_pkg;
    parameter int unsigned DATA_W_DEF = 32;
    parameter int unsigned TAG_W_DEF  = 6;
    parameter int unsigned LANES_DEF  = 4;
    parameter int unsigned DEPTH_DEF  = 3;
endpackage

// File: rtl/bp_result_history.sv
module bp_result_history #(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic [TAG_W-1:0]        in_tag_i,
    input  logic [DATA_W-1:0]       in_data_i,
    output logic [DEPTH-1:0]        lvl_valid_o,
    output logic [DEPTH*TAG_W-1:0]  lvl_tag_o,
    output logic [DEPTH*DATA_W-1:0] lvl_data_o
);
    // level 0 is the live broadcast; level k is k cycles old
    assign lvl_valid_o[0]          = in_valid_i;
    assign lvl_tag_o[0 +: TAG_W]   = in_tag_i;
    assign lvl_data_o[0 +: DATA_W] = in_data_i;

    generate
        if (DEPTH > 1) begin : g_hist
            localparam int unsigned HN = DEPTH - 1;
            logic              hv_q [HN];
            logic [TAG_W-1:0]  ht_q [HN];
            logic [DATA_W-1:0] hd_q [HN];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < int'(HN); j++) begin
                        hv_q[j] <= 1'b0;
                        ht_q[j] <= '0;
                        hd_q[j] <= '0;
                    end
                end else begin
                    hv_q[0] <= in_valid_i;
                    ht_q[0] <= in_tag_i;
                    hd_q[0] <= in_data_i;
                    for (int j = 1; j < int'(HN); j++) begin
                        hv_q[j] <= hv_q[j-1];
                        ht_q[j] <= ht_q[j-1];
                        hd_q[j] <= hd_q[j-1];
                    end
                end
            end

            for (genvar k = 1; k < DEPTH; k++) begin : g_lvl
                assign lvl_valid_o[k]               = hv_q[k-1];
                assign lvl_tag_o[k*TAG_W +: TAG_W]  = ht_q[k-1];
                assign lvl_data_o[k*DATA_W +: DATA_W] = hd_q[k-1];
            end
        end
    endgenerate
endmodule

// File: rtl/bp_tag_select.sv
module bp_tag_select #(
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 12
) (
    input  logic [TAG_W-1:0]          src_tag_i,
    input  logic [DATA_W-1:0]         rf_data_i,
    input  logic [ENTRIES-1:0]        ent_valid_i,
    input  logic [ENTRIES*TAG_W-1:0]  ent_tag_i,
    input  logic [ENTRIES*DATA_W-1:0] ent_data_i,
    output logic [DATA_W-1:0]         data_o
);
    logic [ENTRIES-1:0] match;

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign match[e] = ent_valid_i[e] &&
                              (ent_tag_i[e*TAG_W +: TAG_W] == src_tag_i);
        end
    endgenerate

    // lower entry index = younger level; scanning downward lets it win
    always_comb begin
        data_o = rf_data_i;
        for (int e = int'(ENTRIES) - 1; e >= 0; e--) begin
            if (match[e]) data_o = ent_data_i[e*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/bp_operand_net.sv
module bp_operand_net
    import bypass_net_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TAG_W  = TAG_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        res_valid_i,
    input  logic [LANES*TAG_W-1:0]  res_tag_i,
    input  logic [LANES*DATA_W-1:0] res_data_i,
    input  logic                    issue_valid_i,
    input  logic [TAG_W-1:0]        src_l_tag_i,
    input  logic [TAG_W-1:0]        src_r_tag_i,
    input  logic [DATA_W-1:0]       rf_l_data_i,
    input  logic [DATA_W-1:0]       rf_r_data_i,
    output logic                    op_valid_o,
    output logic [DATA_W-1:0]       op_l_data_o,
    output logic [DATA_W-1:0]       op_r_data_o
);
    localparam int unsigned ENTRIES = LANES * DEPTH;

    logic [ENTRIES-1:0]        ent_valid;
    logic [ENTRIES*TAG_W-1:0]  ent_tag;
    logic [ENTRIES*DATA_W-1:0] ent_data;
    logic [DATA_W-1:0]         sel_l, sel_r;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [DEPTH-1:0]        lv;
            logic [DEPTH*TAG_W-1:0]  lt;
            logic [DEPTH*DATA_W-1:0] ld;

            bp_result_history #(
                .TAG_W (TAG_W),
                .DATA_W(DATA_W),
                .DEPTH (DEPTH)
            ) hist_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .in_valid_i (res_valid_i[ln]),
                .in_tag_i   (res_tag_i[ln*TAG_W +: TAG_W]),
                .in_data_i  (res_data_i[ln*DATA_W +: DATA_W]),
                .lvl_valid_o(lv),
                .lvl_tag_o  (lt),
                .lvl_data_o (ld)
            );

            // entry index = level * LANES + lane
            for (genvar lv_i = 0; lv_i < DEPTH; lv_i++) begin : g_lvl
                localparam int unsigned E = lv_i * LANES + ln;
                assign ent_valid[E]                 = lv[lv_i];
                assign ent_tag[E*TAG_W +: TAG_W]    = lt[lv_i*TAG_W +: TAG_W];
                assign ent_data[E*DATA_W +: DATA_W] = ld[lv_i*DATA_W +: DATA_W];
            end
        end
    endgenerate

    bp_tag_select #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) sel_l_i (
        .src_tag_i  (src_l_tag_i),
        .rf_data_i  (rf_l_data_i),
        .ent_valid_i(ent_valid),
        .ent_tag_i  (ent_tag),
        .ent_data_i (ent_data),
        .data_o     (sel_l)
    );

    bp_tag_select #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) sel_r_i (
        .src_tag_i  (src_r_tag_i),
        .rf_data_i  (rf_r_data_i),
        .ent_valid_i(ent_valid),
        .ent_tag_i  (ent_tag),
        .ent_data_i (ent_data),
        .data_o     (sel_r)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid_o  <= 1'b0;
            op_l_data_o <= '0;
            op_r_data_o <= '0;
        end else begin
            op_valid_o <= issue_valid_i;
            if (issue_valid_i) begin
                op_l_data_o <= sel_l;
                op_r_data_o <= sel_r;
            end
        end
    end
endmodule

// File: rtl/bp_operand_net_chk.sv
module bp_operand_net_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        res_valid_i,
    input logic [LANES*TAG_W-1:0]  res_tag_i,
    input logic [LANES*DATA_W-1:0] res_data_i,
    input logic                    issue_valid_i,
    input logic [TAG_W-1:0]        src_l_tag_i,
    input logic [TAG_W-1:0]        src_r_tag_i,
    input logic                    op_valid_o,
    input logic [DATA_W-1:0]       op_l_data_o,
    input logic [DATA_W-1:0]       op_r_data_o
);
    assert_valid_follows_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_i |=> op_valid_o);

    assert_no_valid_without_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_i |=> !op_valid_o);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_i |=> ($stable(op_l_data_o) && $stable(op_r_data_o)));

    // a live lane-0 match is at the youngest level and wins (tags unique per level)
    assert_live_lane0_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && res_valid_i[0] && (res_tag_i[TAG_W-1:0] == src_l_tag_i))
        |=> (op_l_data_o == $past(res_data_i[DATA_W-1:0])));

    assert_live_lane0_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && res_valid_i[0] && (res_tag_i[TAG_W-1:0] == src_r_tag_i))
        |=> (op_r_data_o == $past(res_data_i[DATA_W-1:0])));
endmodule

bind bp_operand_net bp_operand_net_chk #(
    .DATA_W(DATA_W),
    .TAG_W (TAG_W),
    .LANES (LANES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid_i  (res_valid_i),
    .res_tag_i    (res_tag_i),
    .res_data_i   (res_data_i),
    .issue_valid_i(issue_valid_i),
    .src_l_tag_i  (src_l_tag_i),
    .src_r_tag_i  (src_r_tag_i),
    .op_valid_o   (op_valid_o),
    .op_l_data_o  (op_l_data_o),
    .op_r_data_o  (op_r_data_o)
);

// File: tb/bp_operand_net_tb_top.sv
module bp_operand_net_tb_top;
    localparam int DW = 32;
    localparam int TW = 6;
    localparam int NL = 4;
    localparam int D  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0]    res_valid_i = '0;
    logic [NL*TW-1:0] res_tag_i = '0;
    logic [NL*DW-1:0] res_data_i = '0;
    logic             issue_valid_i = 1'b0;
    logic [TW-1:0]    src_l_tag_i = '0, src_r_tag_i = '0;
    logic [DW-1:0]    rf_l_data_i = '0, rf_r_data_i = '0;
    logic             op_valid_o;
    logic [DW-1:0]    op_l_data_o, op_r_data_o;

    always #4 clk = ~clk;

    bp_operand_net #(.DATA_W(DW), .TAG_W(TW), .LANES(NL), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_data_i(res_data_i),
        .issue_valid_i(issue_valid_i),
        .src_l_tag_i(src_l_tag_i), .src_r_tag_i(src_r_tag_i),
        .rf_l_data_i(rf_l_data_i), .rf_r_data_i(rf_r_data_i),
        .op_valid_o(op_valid_o), .op_l_data_o(op_l_data_o), .op_r_data_o(op_r_data_o)
    );

    typedef struct {
        logic          vld;
        logic [DW-1:0] l;
        logic [DW-1:0] r;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of broadcast history: index 0 = this cycle
    logic          mv [D][NL];
    logic [TW-1:0] mt [D][NL];
    logic [DW-1:0] md [D][NL];
    logic          bv [NL];
    logic [TW-1:0] bt [NL];
    logic [DW-1:0] bd [NL];
    logic [DW-1:0] last_l = '0, last_r = '0;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] expv, string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] lookup(logic [TW-1:0] tag, logic [DW-1:0] rf);
        for (int k = 0; k < D; k++)
            for (int n = 0; n < NL; n++)
                if (mv[k][n] && mt[k][n] == tag) return md[k][n];
        return rf;
    endfunction

    task automatic clear_bcast();
        for (int n = 0; n < NL; n++) begin
            bv[n] = 1'b0; bt[n] = '0; bd[n] = '0;
        end
    endtask

    task automatic step(logic iss, logic [TW-1:0] tl, logic [TW-1:0] tr,
                        logic [DW-1:0] rl, logic [DW-1:0] rr, string req);
        exp_t it;
        @(negedge clk);
        for (int n = 0; n < NL; n++) begin
            res_valid_i[n]         = bv[n];
            res_tag_i[n*TW +: TW]  = bt[n];
            res_data_i[n*DW +: DW] = bd[n];
            mv[0][n] = bv[n]; mt[0][n] = bt[n]; md[0][n] = bd[n];
        end
        issue_valid_i = iss;
        src_l_tag_i = tl; src_r_tag_i = tr;
        rf_l_data_i = rl; rf_r_data_i = rr;
        it.vld = iss;
        it.l = iss ? lookup(tl, rl) : last_l;
        it.r = iss ? lookup(tr, rr) : last_r;
        it.req = req;
        last_l = it.l; last_r = it.r;
        exp_q.push_back(it);
        @(posedge clk);
        for (int k = D - 1; k > 0; k--)
            for (int n = 0; n < NL; n++) begin
                mv[k][n] = mv[k-1][n]; mt[k][n] = mt[k-1][n]; md[k][n] = md[k-1][n];
            end
        clear_bcast();
    endtask

    // monitor: compare one pushed item per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                check("R2", {31'b0, op_valid_o}, {31'b0, it.vld}, "op_valid");
                check(it.req, op_l_data_o, it.l, "left operand");
                check(it.req, op_r_data_o, it.r, "right operand");
            end
        end
    end

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
    end

    initial begin
        wait (done);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < D; k++)
            for (int n = 0; n < NL; n++) begin
                mv[k][n] = 1'b0; mt[k][n] = '0; md[k][n] = '0;
            end
        clear_bcast();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", {31'b0, op_valid_o}, 32'd0, "valid in reset");
        check("R1", op_l_data_o, 32'd0, "left in reset");
        check("R1", op_r_data_o, 32'd0, "right in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", op_l_data_o, 32'd0, "left after reset");

        // R5: no broadcasts, register file values used
        step(1, 6'd5, 6'd6, 32'h1111_0005, 32'h2222_0006, "R5");

        // R3: live broadcast on lane 2, tag 9; right misses (R9)
        bv[2] = 1; bt[2] = 6'd9; bd[2] = 32'hA000_0009;
        step(1, 6'd9, 6'd7, 32'hDEAD_0001, 32'h3333_0007, "R3");
        // R4: one and two cycles old
        step(1, 6'd9, 6'd9, 32'hDEAD_0002, 32'hDEAD_0003, "R4");
        step(1, 6'd3, 6'd9, 32'h4444_0003, 32'hDEAD_0004, "R4");
        // R6: DEPTH cycles old, out of window
        step(1, 6'd9, 6'd9, 32'h5555_0009, 32'h6666_0009, "R6");

        // R7: invalid broadcast with matching tag
        bv[1] = 0; bt[1] = 6'd12; bd[1] = 32'hBAD0_0012;
        step(1, 6'd12, 6'd12, 32'h7777_0012, 32'h8888_0012, "R7");

        // R8: same tag at two levels, youngest wins
        bv[0] = 1; bt[0] = 6'd20; bd[0] = 32'hC0DE_0001;
        step(0, 6'd0, 6'd0, 32'h0, 32'h0, "R10");
        bv[3] = 1; bt[3] = 6'd20; bd[3] = 32'hC0DE_0002;
        step(1, 6'd20, 6'd21, 32'hDEAD_0020, 32'h9999_0021, "R8");
        step(1, 6'd21, 6'd20, 32'h9999_0021, 32'hDEAD_0020, "R8");

        // R9: left and right take different lanes
        bv[0] = 1; bt[0] = 6'd1; bd[0] = 32'h0101_0101;
        bv[3] = 1; bt[3] = 6'd2; bd[3] = 32'h0202_0202;
        step(1, 6'd2, 6'd1, 32'hDEAD_0002, 32'hDEAD_0001, "R9");
        // R9: left from older level, right from live lane 1
        bv[1] = 1; bt[1] = 6'd33; bd[1] = 32'h3333_3333;
        step(1, 6'd1, 6'd33, 32'hDEAD_0001, 32'hDEAD_0033, "R9");

        // R10: idle cycles with activity on all other inputs
        bv[2] = 1; bt[2] = 6'd40; bd[2] = 32'h4040_4040;
        step(0, 6'd40, 6'd40, 32'hFFFF_FFFF, 32'hEEEE_EEEE, "R10");
        step(0, 6'd1, 6'd2, 32'h1234_5678, 32'h8765_4321, "R10");
        step(1, 6'd40, 6'd63, 32'hDEAD_0040, 32'h6363_6363, "R4");
        step(0, 6'd0, 6'd0, 32'h0, 32'h0, "R10");

        repeat (2) @(posedge clk);
        #3;
        done = 1;
    end
endmodule